// File: doc/BRIEF.md
# Protected-Mode Segment Register Loader

This block loads a 16-bit selector into one segment register and fills the register's hidden descriptor cache. A request arrives with a valid/ready handshake. The selector is split into three fields: a 13-bit table index in bits 15:3, a table-select bit in bit 2 and a requester privilege level in bits 1:0. The global descriptor table is described by a 48-bit table register. Its upper 32 bits hold the linear base and its lower 16 bits hold the byte limit.

For a selector that passes the checks, the block reads the 8-byte descriptor as two 32-bit words from `base + index*8`. It then checks that the descriptor is present. It writes the high word back with the accessed flag set, and only then latches base, expanded limit and attributes into the cache. Each load ends with one of two one-cycle outputs: a `done` pulse, or a `fault` pulse carrying a code. A null selector loads a cache entry marked invalid. A local-table selector is refused.

Top module: `seg_sel_loader`

## Requirements
- R1: After reset, `req_ready` is 1, `done`, `fault`, `mem_req` and `cache_valid` are 0.
- R2: A selector with bit 2 set ends with `fault` and `fault_code` 3 (unsupported table), issues no memory request and leaves the cache unchanged.
- R3: A null selector (bits 15:2 all zero) ends with `done`, no fault and no memory request. The cache becomes invalid, with base, limit and attributes all zero, and `cache_sel` equal to the selector including its privilege bits.
- R4: When `index*8+7` exceeds the 16-bit table limit, the load ends with `fault` and `fault_code` 1 (general protection) before any memory request. A last byte equal to the limit is accepted.
- R5: A checked selector causes a read of the low word at `base+index*8`, followed by a read of the high word at that address plus 4. Each request holds address and direction until `mem_ack`.
- R6: If bit 15 of the high word (present) is 0, the load ends with `fault` and `fault_code` 2 after exactly two reads. No write is issued and the cache is unchanged.
- R7: A present descriptor causes exactly one write of the high word to its own address, with bit 8 (accessed) set and every other bit unchanged. `done` follows that write.
- R8: On `done` after a present descriptor, `cache_valid` is 1, `cache_sel` is the selector, and `cache_base` is {high[31:24], high[7:0], low[31:16]}.
- R9: The raw 20-bit limit is {high[19:16], low[15:0]}. `cache_limit` is that value zero-extended when high bit 23 (granularity) is 0, and that value followed by twelve 1 bits when it is 1.
- R10: `cache_attr` packs [10]=granularity (high bit 23), [9]=default size (bit 22), [8]=software bit (bit 20), [7]=present (bit 15), [6:5]=privilege (bits 14:13), [4]=code/data flag (bit 12), [3:0]=type (bits 11:8, with bit 0 as written back).
- R11: `req_ready` is 0 while a memory sequence is in progress. `done` and `fault` are single-cycle pulses, never high together. `fault_code` is 0 when no fault is signalled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_reg | input | 48 | Table register: [47:16] linear base, [15:0] byte limit |
| req_valid | input | 1 | Load request valid |
| req_ready | output | 1 | Block can accept a load |
| req_sel | input | 16 | Selector to load |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word address of the access (byte address) |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes in this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| done | output | 1 | Load finished without fault |
| fault | output | 1 | Load refused |
| fault_code | output | 2 | 1 general protection, 2 not present, 3 unsupported table |
| cache_valid | output | 1 | Hidden cache holds a usable descriptor |
| cache_sel | output | 16 | Selector held by the register |
| cache_base | output | 32 | Cached segment base |
| cache_limit | output | 32 | Cached expanded limit |
| cache_attr | output | 11 | Cached attributes, packed as in R10 |

## Verification
Selectors are chosen so that each leaves the block at a different point: at the table-select test, at the null test, at the limit comparison, after two reads at the present bit, or after the full three-access sequence. The access count tells these exits apart. Table limits are moved so that the same index lands just inside, and then just outside, the last-byte boundary. Descriptors with granularity set and clear, several privilege and type values, and one that is already marked accessed separate the limit expansion, the field packing and the write-back contents. Reloading a descriptor after its write-back shows that the memory copy was updated.

// File: rtl/seg_load_pkg.sv
package seg_load_pkg;

    localparam int SEL_W       = 16;
    localparam int ENTRY_SHIFT = 3;
    localparam int IDX_W       = SEL_W - ENTRY_SHIFT;
    localparam int TI_BIT      = 2;
    localparam int RPL_W       = 2;
    localparam int TBL_LIM_W   = 16;
    localparam int LIN_W       = 32;
    localparam int TBL_REG_W   = LIN_W + TBL_LIM_W;
    localparam int WORD_W      = 32;
    localparam int WORD_BYTES  = WORD_W / 8;
    localparam int RAW_LIM_W   = 20;
    localparam int PAGE_BITS   = LIN_W - RAW_LIM_W;
    localparam int ATTR_W      = 11;

    // high descriptor word field positions
    localparam int HI_TYPE_LSB = 8;
    localparam int HI_S        = 12;
    localparam int HI_DPL_LSB  = 13;
    localparam int HI_P        = 15;
    localparam int HI_LIM_LSB  = 16;
    localparam int HI_AVL      = 20;
    localparam int HI_DB       = 22;
    localparam int HI_G        = 23;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_GP    = 2'd1,
        FLT_NP    = 2'd2,
        FLT_TABLE = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD_LO,
        ST_RD_HI,
        ST_WR_HI
    } ld_state_e;

    typedef struct packed {
        logic       g;
        logic       db;
        logic       avl;
        logic       p;
        logic [1:0] dpl;
        logic       s;
        logic [3:0] typ;
    } seg_attr_t;

    typedef struct packed {
        logic [LIN_W-1:0] base;
        logic [LIN_W-1:0] limit;
        seg_attr_t        attr;
    } seg_cache_t;

    function automatic logic [LIN_W-1:0] expand_limit(
        input logic [RAW_LIM_W-1:0] raw,
        input logic                 gran
    );
        return gran ? {raw, {PAGE_BITS{1'b1}}} : {{PAGE_BITS{1'b0}}, raw};
    endfunction

    function automatic logic [WORD_W-1:0] set_accessed(input logic [WORD_W-1:0] hi);
        logic [WORD_W-1:0] r;
        r = hi;
        r[HI_TYPE_LSB] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/seg_sel_split.sv
module seg_sel_split
    import seg_load_pkg::*;
(
    input  logic [SEL_W-1:0]     sel,
    input  logic [LIN_W-1:0]     tbl_base,
    input  logic [TBL_LIM_W-1:0] tbl_limit,
    output logic                 is_null,
    output logic                 tbl_fault,
    output logic                 lim_fault,
    output logic [LIN_W-1:0]     desc_addr
);

    logic [IDX_W-1:0]     idx;
    logic                 ti;
    logic [RPL_W-1:0]     unused_rpl;
    logic [TBL_LIM_W-1:0] last_byte;

    assign idx        = sel[SEL_W-1:ENTRY_SHIFT];
    assign ti         = sel[TI_BIT];
    assign unused_rpl = sel[RPL_W-1:0];
    assign last_byte  = TBL_LIM_W'({idx, {ENTRY_SHIFT{1'b1}}});

    always_comb begin
        tbl_fault = ti;
        is_null   = !ti && (idx == '0);
        lim_fault = !ti && !is_null && (last_byte > tbl_limit);
        desc_addr = tbl_base + LIN_W'({idx, {ENTRY_SHIFT{1'b0}}});
    end

endmodule

// File: rtl/seg_desc_unpack.sv
module seg_desc_unpack
    import seg_load_pkg::*;
(
    input  logic [WORD_W-1:0] lo_word,
    input  logic [WORD_W-1:0] hi_word,
    output seg_cache_t        fill
);

    logic [RAW_LIM_W-1:0] raw_lim;
    logic                 unused_hi21;

    assign unused_hi21 = hi_word[21];
    assign raw_lim     = {hi_word[HI_LIM_LSB+3:HI_LIM_LSB], lo_word[15:0]};

    always_comb begin
        fill.base       = {hi_word[31:24], hi_word[7:0], lo_word[31:16]};
        fill.limit      = expand_limit(raw_lim, hi_word[HI_G]);
        fill.attr.g     = hi_word[HI_G];
        fill.attr.db    = hi_word[HI_DB];
        fill.attr.avl   = hi_word[HI_AVL];
        fill.attr.p     = hi_word[HI_P];
        fill.attr.dpl   = hi_word[HI_DPL_LSB+1:HI_DPL_LSB];
        fill.attr.s     = hi_word[HI_S];
        fill.attr.typ   = hi_word[HI_TYPE_LSB+3:HI_TYPE_LSB];
    end

endmodule

// File: rtl/seg_sel_loader.sv
module seg_sel_loader
    import seg_load_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [TBL_REG_W-1:0] tbl_reg,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [SEL_W-1:0]     req_sel,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [LIN_W-1:0]     mem_addr,
    output logic [WORD_W-1:0]    mem_wdata,
    input  logic                 mem_ack,
    input  logic [WORD_W-1:0]    mem_rdata,
    output logic                 done,
    output logic                 fault,
    output logic [1:0]           fault_code,
    output logic                 cache_valid,
    output logic [SEL_W-1:0]     cache_sel,
    output logic [LIN_W-1:0]     cache_base,
    output logic [LIN_W-1:0]     cache_limit,
    output logic [ATTR_W-1:0]    cache_attr
);

    ld_state_e         state_q;
    logic [SEL_W-1:0]  sel_q;
    logic [LIN_W-1:0]  addr_q;
    logic [WORD_W-1:0] lo_q;
    logic [WORD_W-1:0] hi_q;
    logic [WORD_W-1:0] hi_marked;
    logic              done_q;
    logic              fault_q;
    fault_e            code_q;
    logic              cvalid_q;
    logic [SEL_W-1:0]  csel_q;
    seg_cache_t        cache_q;

    logic              is_null;
    logic              tbl_fault;
    logic              lim_fault;
    logic [LIN_W-1:0]  desc_addr;
    seg_cache_t        fill;

    seg_sel_split u_split (
        .sel       (req_sel),
        .tbl_base  (tbl_reg[TBL_REG_W-1:TBL_LIM_W]),
        .tbl_limit (tbl_reg[TBL_LIM_W-1:0]),
        .is_null   (is_null),
        .tbl_fault (tbl_fault),
        .lim_fault (lim_fault),
        .desc_addr (desc_addr)
    );

    assign hi_marked = set_accessed(hi_q);

    seg_desc_unpack u_unpack (
        .lo_word (lo_q),
        .hi_word (hi_marked),
        .fill    (fill)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            sel_q    <= '0;
            addr_q   <= '0;
            lo_q     <= '0;
            hi_q     <= '0;
            done_q   <= 1'b0;
            fault_q  <= 1'b0;
            code_q   <= FLT_NONE;
            cvalid_q <= 1'b0;
            csel_q   <= '0;
            cache_q  <= '0;
        end else begin
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            code_q  <= FLT_NONE;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        sel_q  <= req_sel;
                        addr_q <= desc_addr;
                        if (tbl_fault) begin
                            fault_q <= 1'b1;
                            code_q  <= FLT_TABLE;
                        end else if (is_null) begin
                            done_q   <= 1'b1;
                            cvalid_q <= 1'b0;
                            csel_q   <= req_sel;
                            cache_q  <= '0;
                        end else if (lim_fault) begin
                            fault_q <= 1'b1;
                            code_q  <= FLT_GP;
                        end else begin
                            state_q <= ST_RD_LO;
                        end
                    end
                end
                ST_RD_LO: begin
                    if (mem_ack) begin
                        lo_q    <= mem_rdata;
                        state_q <= ST_RD_HI;
                    end
                end
                ST_RD_HI: begin
                    if (mem_ack) begin
                        hi_q <= mem_rdata;
                        if (!mem_rdata[HI_P]) begin
                            fault_q <= 1'b1;
                            code_q  <= FLT_NP;
                            state_q <= ST_IDLE;
                        end else begin
                            state_q <= ST_WR_HI;
                        end
                    end
                end
                ST_WR_HI: begin
                    if (mem_ack) begin
                        cvalid_q <= 1'b1;
                        csel_q   <= sel_q;
                        cache_q  <= fill;
                        done_q   <= 1'b1;
                        state_q  <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready = (state_q == ST_IDLE);
        mem_req   = (state_q != ST_IDLE);
        mem_we    = (state_q == ST_WR_HI);
        mem_addr  = (state_q == ST_RD_LO) ? addr_q : addr_q + LIN_W'(WORD_BYTES);
        mem_wdata = hi_marked;
    end

    assign done        = done_q;
    assign fault       = fault_q;
    assign fault_code  = code_q;
    assign cache_valid = cvalid_q;
    assign cache_sel   = csel_q;
    assign cache_base  = cache_q.base;
    assign cache_limit = cache_q.limit;
    assign cache_attr  = cache_q.attr;

endmodule

// File: rtl/seg_sel_loader_chk.sv
module seg_sel_loader_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_ready,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        mem_ack,
    input logic        done,
    input logic        fault,
    input logic [1:0]  fault_code,
    input logic        cache_valid,
    input logic [15:0] cache_sel,
    input logic [31:0] cache_base,
    input logic [31:0] cache_limit,
    input logic [10:0] cache_attr
);

    AST_DONE_FAULT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done && fault)); // R11

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !req_ready); // R11

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R5

    AST_WRITE_ONLY_PRESENT: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> mem_wdata[15]); // R6

    AST_FAULT_HAS_CODE: assert property (@(posedge clk) disable iff (rst)
        fault |-> (fault_code != 2'd0)); // R2

    AST_FAULT_KEEPS_CACHE: assert property (@(posedge clk) disable iff (rst)
        fault |-> ($stable(cache_valid) && $stable(cache_base)
                   && $stable(cache_limit) && $stable(cache_attr))); // R6

    AST_NULL_INVALID: assert property (@(posedge clk) disable iff (rst)
        (done && (cache_sel[15:2] == 14'd0)) |-> !cache_valid); // R3

    AST_VALID_PRESENT_ACCESSED: assert property (@(posedge clk) disable iff (rst)
        (done && cache_valid) |-> (cache_attr[7] && cache_attr[0])); // R7

endmodule

bind seg_sel_loader seg_sel_loader_chk chk_i (.*);

// File: tb/seg_sel_loader_tb_top.sv
`timescale 1ns/1ps
module seg_sel_loader_tb_top;

    typedef struct {
        logic        is_fault;
        logic [1:0]  code;
        logic        valid;
        logic [15:0] sel;
        logic [31:0] base;
        logic [31:0] limit;
        logic [10:0] attr;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [47:0] tbl_reg;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_sel = 16'h0;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        done, fault, cache_valid;
    logic [1:0]  fault_code;
    logic [15:0] cache_sel;
    logic [31:0] cache_base, cache_limit;
    logic [10:0] cache_attr;

    logic [31:0] mem [0:63];
    exp_t        sb[$];
    int          vec_cnt = 0, err_cnt = 0, seen = 0, issued = 0, acc_cnt = 0;
    logic [31:0] exp_rd_next, exp_wr_addr, exp_wr_data;
    logic        m_valid = 1'b0;
    logic [15:0] m_sel = 16'h0;
    logic [31:0] m_base = 0, m_limit = 0;
    logic [10:0] m_attr = 0;
    logic [15:0] cur_lim;

    localparam logic [31:0] TBL_BASE = 32'h0000_0100;

    always #2.5 clk = ~clk;

    assign tbl_reg   = {TBL_BASE, cur_lim};
    assign mem_rdata = mem[mem_addr[7:2]];

    seg_sel_loader dut_i (
        .clk(clk), .rst(rst), .tbl_reg(tbl_reg),
        .req_valid(req_valid), .req_ready(req_ready), .req_sel(req_sel),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done(done), .fault(fault), .fault_code(fault_code),
        .cache_valid(cache_valid), .cache_sel(cache_sel),
        .cache_base(cache_base), .cache_limit(cache_limit), .cache_attr(cache_attr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vec_cnt++;
        if (act !== exp) begin
            err_cnt++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // memory model: one-cycle acknowledge
    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && mem_ack) begin
                acc_cnt++;
                if (mem_we) begin
                    chk("R7 write address", mem_addr, exp_wr_addr);
                    chk("R7 write data", mem_wdata, exp_wr_data);
                    mem[mem_addr[7:2]] <= mem_wdata;
                end else begin
                    chk("R5 read address", mem_addr, exp_rd_next);
                    exp_rd_next = exp_rd_next + 32'd4;
                end
            end
        end
    end

    // monitor: compares each result against the scoreboard
    always @(negedge clk) begin
        if (!rst && (done || fault)) begin
            exp_t e;
            chk("R11 exclusive pulses", {31'd0, done && fault}, 32'd0);
            if (sb.size() == 0) begin
                chk("R11 unexpected result", 32'd1, 32'd0);
            end else begin
                e = sb.pop_front();
                chk({e.tag, " fault flag"}, {31'd0, fault}, {31'd0, e.is_fault});
                chk({e.tag, " fault code"}, {30'd0, fault_code}, {30'd0, e.code});
                chk({e.tag, " cache valid"}, {31'd0, cache_valid}, {31'd0, e.valid});
                chk({e.tag, " cache sel"}, {16'd0, cache_sel}, {16'd0, e.sel});
                chk({e.tag, " R8 base"}, cache_base, e.base);
                chk({e.tag, " R9 limit"}, cache_limit, e.limit);
                chk({e.tag, " R10 attr"}, {21'd0, cache_attr}, {21'd0, e.attr});
            end
            seen++;
        end
    end

    task automatic put_desc(input int idx, input logic [31:0] base, input logic [19:0] lim,
                            input logic [3:0] typ, input logic s, input logic [1:0] dpl,
                            input logic p, input logic avl, input logic db, input logic g);
        mem[idx*2]   = {base[15:0], lim[15:0]};
        mem[idx*2+1] = {base[31:24], g, db, 1'b0, avl, lim[19:16], p, dpl, s, typ, base[23:16]};
    endtask

    task automatic do_load(input logic [15:0] sel, input string tag);
        exp_t        e;
        int          exp_acc;
        int          a0;
        logic [31:0] lo, hi, hiw;
        logic [19:0] raw;
        e.is_fault = 1'b0; e.code = 2'd0;
        e.valid = m_valid; e.sel = m_sel; e.base = m_base; e.limit = m_limit; e.attr = m_attr;
        e.tag = tag;
        exp_acc = 0;
        exp_rd_next = TBL_BASE + {16'd0, sel[15:3], 3'b000};
        if (sel[2]) begin
            e.is_fault = 1'b1; e.code = 2'd3;
        end else if (sel[15:2] == 14'd0) begin
            m_valid = 1'b0; m_sel = sel; m_base = 0; m_limit = 0; m_attr = 0;
            e.valid = 1'b0; e.sel = sel; e.base = 0; e.limit = 0; e.attr = 0;
        end else if ({sel[15:3], 3'b111} > cur_lim) begin
            e.is_fault = 1'b1; e.code = 2'd1;
        end else begin
            lo = mem[sel[15:3]*2];
            hi = mem[sel[15:3]*2+1];
            if (!hi[15]) begin
                e.is_fault = 1'b1; e.code = 2'd2; exp_acc = 2;
            end else begin
                exp_acc = 3;
                hiw = hi | 32'h0000_0100;
                exp_wr_addr = exp_rd_next + 32'd4;
                exp_wr_data = hiw;
                raw = {hi[19:16], lo[15:0]};
                m_valid = 1'b1; m_sel = sel;
                m_base  = {hi[31:24], hi[7:0], lo[31:16]};
                m_limit = hi[23] ? {raw, 12'hFFF} : {12'h000, raw};
                m_attr  = {hi[23], hi[22], hi[20], hi[15], hi[14:13], hi[12], hiw[11:8]};
                e.valid = m_valid; e.sel = m_sel; e.base = m_base; e.limit = m_limit; e.attr = m_attr;
            end
        end
        sb.push_back(e);
        issued++;
        a0 = acc_cnt;
        @(negedge clk);
        req_valid = 1'b1;
        req_sel   = sel;
        @(negedge clk);
        req_valid = 1'b0;
        if (exp_acc > 0) chk("R11 ready low while busy", {31'd0, req_ready}, 32'd0);
        while (seen < issued) @(negedge clk);
        @(negedge clk);
        chk("R11 pulses one cycle", {30'd0, done, fault}, 32'd0);
        chk({tag, " access count"}, acc_cnt - a0, exp_acc);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
        put_desc(1, 32'h1234_5678, 20'h0ABCD, 4'h2, 1'b1, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0);
        put_desc(2, 32'hCAFE_0000, 20'h00012, 4'hA, 1'b1, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1);
        put_desc(3, 32'h0000_4000, 20'h00FFF, 4'h2, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0);
        put_desc(7, 32'h00FF_00AA, 20'hFFFFF, 4'h3, 1'b0, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1);
        cur_lim = 16'h003F;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 req_ready", {31'd0, req_ready}, 32'd1);
        chk("R1 done/fault", {30'd0, done, fault}, 32'd0);
        chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
        chk("R1 cache_valid", {31'd0, cache_valid}, 32'd0);

        do_load(16'h000B, "R8 index1 rpl3");
        do_load(16'h0010, "R9 index2 gran");
        do_load(16'h0018, "R6 not present");
        do_load(16'h0004, "R2 local table");
        do_load(16'h000C, "R2 local table idx1");
        do_load(16'h0003, "R3 null rpl3");
        do_load(16'h0038, "R4 last byte equals limit");
        do_load(16'h0040, "R4 beyond limit");
        do_load(16'h0008, "R7 reload accessed");
        cur_lim = 16'h000F;
        do_load(16'h0008, "R4 tight limit pass");
        do_load(16'h0010, "R4 tight limit fault");
        cur_lim = 16'h000E;
        do_load(16'h0009, "R4 off by one");
        do_load(16'h0000, "R3 null rpl0");

        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        err_cnt++;
        vec_cnt++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
        $finish;
    end

endmodule